// File: doc/BRIEF.md
# Output Sample Readback Port

This block lets an external processor fetch the newest complex output sample over a byte-wide register bus. A new sample arrives on a valid/data input. Its 16-bit in-phase and quadrature words are copied into four byte registers on one clock edge. A status register tracks whether a fresh sample is waiting and whether one was overwritten before the processor read it. An interrupt line tells the processor that a sample is ready, and the processor can enable or mask it.

In real mode the sample stream is a single real sequence on the in-phase input. The even-time sample is held back until its odd-time partner arrives. The pair is then published together: the even sample in the in-phase bytes and the odd sample in the quadrature bytes.

The bus decoder accepts two strobe conventions without a mode pin. In the standard convention, a high read-enable with chip-enable low selects a read. If read-enable is tied low, chip-enable acts as a chip-select and write-enable acts as a read/not-write select.

Top module: `sample_readback_port`

## Requirements
- R1: After reset the status register, all four sample bytes, the interrupt and the bus output enable are all zero.
- R2: In complex mode a valid pulse loads the in-phase word into address 12 (low byte) and address 13 (high byte), and the quadrature word into address 14 (low byte) and address 15 (high byte). All four bytes are updated on the same edge and hold their values until the next load.
- R3: In real mode the first valid sample after entering the mode is held back and nothing is published. The next valid sample publishes the pair: the held sample goes to addresses 12/13 and the new one to addresses 14/15. Only then is the ready flag set.
- R4: Status register address 9, bit 0 (ready) is set by every load. It is cleared by a read access to address 15.
- R5: Status bit 1 (missed) is set when a load occurs while ready is still set. It stays set until a write to address 9 with data bit 1 equal to 1. A write with bit 1 equal to 0 leaves it unchanged.
- R6: Status bit 2 is the interrupt enable. It is written by any write to address 9 and is 0 after reset. The interrupt output is high exactly while ready and the interrupt enable are both 1.
- R7: A read access is chip-enable low with read-enable high, or chip-enable low with read-enable low and write-enable high. A write access is chip-enable low with read-enable and write-enable both low. The data bus output enable is high only in the cycle after a cycle holding a read access.
- R8: Read data and output enable are registered: they reflect the address and state one clock after the access is sampled. Addresses other than 9 and 12 to 15 read as zero, as do status bits 3 to 7.
- R9: Read and write side effects happen once per access, in its first sampled cycle. A read of address 15 held over several cycles clears ready only once, so a sample loaded during that hold remains ready.
- R10: Writing status bit 0 has no effect on ready. Writes to addresses 12 to 15 do not change the sample bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample strobe |
| smp_i | input | 16 | In-phase word (real sample in real mode) |
| smp_q | input | 16 | Quadrature word (unused in real mode) |
| real_mode | input | 1 | 1 selects real even/odd pairing |
| ce_n | input | 1 | Chip enable, active low |
| rd_en | input | 1 | Read enable, active high; tie low for legacy strobes |
| we_n | input | 1 | Write enable, or read/not-write in legacy strobes |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Drive enable for the data bus |
| irq | output | 1 | Sample-ready interrupt |

## Verification
The hardest situation to reach is a new sample landing in the middle of a read of address 15 that is held over several cycles. That exposes whether the ready clear is tied to the start of the access or to its whole duration. The bench asserts chip-enable on address 15 and keeps it there. It pulses the sample input during the hold, then checks that ready is still set and missed is still clear. Overrun is reached by pushing two samples with no read between them, and the real-mode pairing by toggling the mode input and pushing single samples.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned ADR_STATUS = 9;
  localparam int unsigned ADR_I_LO   = 12;
  localparam int unsigned ADR_I_HI   = 13;
  localparam int unsigned ADR_Q_LO   = 14;
  localparam int unsigned ADR_Q_HI   = 15;

  localparam int unsigned BIT_RDY  = 0;
  localparam int unsigned BIT_MISS = 1;
  localparam int unsigned BIT_IE   = 2;
  localparam int unsigned STAT_USED = 3;

  typedef struct packed {
    logic rd;
    logic wr;
    logic rd_start;
    logic wr_start;
  } bus_evt_t;
endpackage

// File: rtl/srp_bus_decode.sv
module srp_bus_decode
  import srp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ce_n,
  input  logic     rd_en,
  input  logic     we_n,
  output bus_evt_t evt
);
  logic rd_now, wr_now, rd_prev, wr_prev;

  // read-enable high forces a read; with it low, write-enable is a direction bit
  assign rd_now = !ce_n && (rd_en || we_n);
  assign wr_now = !ce_n && !rd_en && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_now;
      wr_prev <= wr_now;
    end
  end

  assign evt.rd       = rd_now;
  assign evt.wr       = wr_now;
  assign evt.rd_start = rd_now && !rd_prev;
  assign evt.wr_start = wr_now && !wr_prev;
endmodule

// File: rtl/srp_sample_capture.sv
module srp_sample_capture #(
  parameter int unsigned SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_i,
  input  logic [SW-1:0] smp_q,
  input  logic          real_mode,
  output logic          load,
  output logic [SW-1:0] i_hold,
  output logic [SW-1:0] q_hold
);
  logic          odd_next;
  logic [SW-1:0] even_q;

  assign load = smp_valid && (!real_mode || odd_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_next <= 1'b0;
      even_q   <= '0;
    end else if (!real_mode) begin
      odd_next <= 1'b0;
    end else if (smp_valid) begin
      odd_next <= !odd_next;
      if (!odd_next) even_q <= smp_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_hold <= '0;
      q_hold <= '0;
    end else if (load) begin
      i_hold <= real_mode ? even_q : smp_i;
      q_hold <= real_mode ? smp_i  : smp_q;
    end
  end
endmodule

// File: rtl/srp_status.sv
module srp_status (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clr_rdy,
  input  logic wr_stat,
  input  logic w_miss,
  input  logic w_ie,
  output logic rdy,
  output logic miss,
  output logic ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy  <= 1'b0;
      miss <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (load)         rdy <= 1'b1;
      else if (clr_rdy) rdy <= 1'b0;

      if (load && rdy && !clr_rdy) miss <= 1'b1;
      else if (wr_stat && w_miss)  miss <= 1'b0;

      if (wr_stat) ie <= w_ie;
    end
  end
endmodule

// File: rtl/sample_readback_port.sv
module sample_readback_port
  import srp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [2*DATA_W-1:0] smp_i,
  input  logic [2*DATA_W-1:0] smp_q,
  input  logic                real_mode,
  input  logic                ce_n,
  input  logic                rd_en,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                rdata_oe,
  output logic                irq
);
  localparam int unsigned SAMP_W = 2 * DATA_W;

  bus_evt_t          evt;
  logic              smp_load;
  logic [SAMP_W-1:0] i_hold, q_hold;
  logic              stat_rdy, stat_miss, stat_ie;
  logic              clr_rdy, wr_stat;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  srp_bus_decode u_dec (
    .clk(clk), .rst(rst), .ce_n(ce_n), .rd_en(rd_en), .we_n(we_n), .evt(evt)
  );

  srp_sample_capture #(.SW(SAMP_W)) u_cap (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .real_mode(real_mode), .load(smp_load), .i_hold(i_hold), .q_hold(q_hold)
  );

  assign clr_rdy = evt.rd_start && (addr == ADDR_W'(ADR_Q_HI));
  assign wr_stat = evt.wr_start && (addr == ADDR_W'(ADR_STATUS));

  srp_status u_stat (
    .clk(clk), .rst(rst), .load(smp_load), .clr_rdy(clr_rdy), .wr_stat(wr_stat),
    .w_miss(wdata[BIT_MISS]), .w_ie(wdata[BIT_IE]),
    .rdy(stat_rdy), .miss(stat_miss), .ie(stat_ie)
  );

  assign unused_wbits = ^{wdata[DATA_W-1:STAT_USED], wdata[BIT_RDY]};

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(ADR_STATUS): begin
        rd_mux[BIT_RDY]  = stat_rdy;
        rd_mux[BIT_MISS] = stat_miss;
        rd_mux[BIT_IE]   = stat_ie;
      end
      ADDR_W'(ADR_I_LO): rd_mux = i_hold[DATA_W-1:0];
      ADDR_W'(ADR_I_HI): rd_mux = i_hold[SAMP_W-1:DATA_W];
      ADDR_W'(ADR_Q_LO): rd_mux = q_hold[DATA_W-1:0];
      ADDR_W'(ADR_Q_HI): rd_mux = q_hold[SAMP_W-1:DATA_W];
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata    <= evt.rd ? rd_mux : '0;
      rdata_oe <= evt.rd;
    end
  end

  assign irq = stat_rdy && stat_ie;
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int unsigned SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          rd_en,
  input logic          we_n,
  input logic          rdata_oe,
  input logic          smp_load,
  input logic          clr_rdy,
  input logic          wr_stat,
  input logic          w_miss,
  input logic          stat_rdy,
  input logic          stat_miss,
  input logic [SW-1:0] i_hold,
  input logic [SW-1:0] q_hold
);
  a_r7_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(!ce_n && (rd_en || we_n)));

  a_r4_ready_from_load: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_rdy) |-> $past(smp_load));

  a_r9_ready_clear_by_read: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_rdy) |-> $past(clr_rdy));

  a_r5_missed_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_miss) |-> $past(wr_stat && w_miss));

  a_r2_bytes_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_load) |-> ($stable(i_hold) && $stable(q_hold)));
endmodule

bind sample_readback_port srp_checker #(.SW(2*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .rd_en(rd_en), .we_n(we_n),
  .rdata_oe(rdata_oe), .smp_load(smp_load), .clr_rdy(clr_rdy),
  .wr_stat(wr_stat), .w_miss(wdata[1]), .stat_rdy(stat_rdy),
  .stat_miss(stat_miss), .i_hold(i_hold), .q_hold(q_hold)
);

// File: tb/sample_readback_port_test.sv
module sample_readback_port_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        smp_valid = 0;
  logic [15:0] smp_i = '0, smp_q = '0;
  logic        real_mode = 0;
  logic        ce_n = 1, rd_en = 1, we_n = 1;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe, irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] d;

  localparam logic [31:0] VEC [4] = '{32'h1234_ABCD, 32'h8001_7FFE,
                                      32'hFFFF_0000, 32'h00A5_5A00};

  sample_readback_port uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .real_mode(real_mode), .ce_n(ce_n), .rd_en(rd_en), .we_n(we_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] i, input logic [15:0] q);
    @(negedge clk); smp_valid = 1; smp_i = i; smp_q = q;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input bit legacy, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 0; rd_en = !legacy; we_n = 1;
    @(negedge clk); v = rdata;
    chk({15'd0, rdata_oe}, 16'd1, "R7 oe during read");
    ce_n = 1; rd_en = 1;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; ce_n = 0; rd_en = 0; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1; rd_en = 1;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk({15'd0, irq}, 16'd0, "R1 irq");
    chk({15'd0, rdata_oe}, 16'd0, "R1 oe");
    bus_rd(4'd9, 0, d);  chk(d, 8'h00, "R1 status");
    bus_rd(4'd12, 0, d); chk(d, 8'h00, "R1 byte12");
    bus_rd(4'd15, 0, d); chk(d, 8'h00, "R1 byte15");

    // R6 enable interrupt, then the vector table (R2, R4, R6)
    bus_wr(4'd9, 8'h04);
    for (int k = 0; k < 4; k++) begin
      push(VEC[k][31:16], VEC[k][15:0]);
      chk({15'd0, irq}, 16'd1, "R6 irq on ready");
      bus_rd(4'd9, 0, d);  chk(d, 8'h05, "R4 ready set");
      bus_rd(4'd12, 0, d); chk(d, VEC[k][23:16], "R2 I low");
      bus_rd(4'd13, 0, d); chk(d, VEC[k][31:24], "R2 I high");
      bus_rd(4'd14, 0, d); chk(d, VEC[k][7:0], "R2 Q low");
      bus_rd(4'd15, 0, d); chk(d, VEC[k][15:8], "R2 Q high");
      bus_rd(4'd9, 0, d);  chk(d, 8'h04, "R4 ready cleared by addr 15");
      chk({15'd0, irq}, 16'd0, "R6 irq drops");
    end

    // R5 overrun, R10 bit 0 write ignored
    push(16'h1111, 16'h2222);
    push(16'h3333, 16'h4444);
    bus_rd(4'd9, 0, d);  chk(d, 8'h07, "R5 missed set");
    bus_wr(4'd9, 8'h04);
    bus_rd(4'd9, 0, d);  chk(d, 8'h07, "R5 write 0 keeps missed");
    bus_rd(4'd12, 0, d); chk(d, 8'h33, "R2 newest I after overrun");
    bus_rd(4'd15, 0, d); chk(d, 8'h44, "R2 newest Q after overrun");
    bus_rd(4'd9, 0, d);  chk(d, 8'h06, "R5 missed survives read");
    bus_wr(4'd9, 8'h05);
    bus_rd(4'd9, 0, d);  chk(d, 8'h06, "R10 bit0 write ignored");
    bus_wr(4'd9, 8'h06);
    bus_rd(4'd9, 0, d);  chk(d, 8'h04, "R5 write 1 clears missed");

    // R3 real mode pairing
    real_mode = 1;
    push(16'hBEEF, 16'h9999);
    bus_rd(4'd9, 0, d);  chk(d, 8'h04, "R3 even sample not published");
    chk({15'd0, irq}, 16'd0, "R3 no irq on even");
    push(16'hCAFE, 16'h8888);
    bus_rd(4'd9, 0, d);  chk(d, 8'h05, "R3 ready after odd");
    bus_rd(4'd12, 0, d); chk(d, 8'hEF, "R3 even low");
    bus_rd(4'd13, 0, d); chk(d, 8'hBE, "R3 even high");
    bus_rd(4'd14, 0, d); chk(d, 8'hFE, "R3 odd low");
    bus_rd(4'd15, 0, d); chk(d, 8'hCA, "R3 odd high");
    real_mode = 0;

    // R9 held read of 15 with a load during the hold
    push(16'h0102, 16'h0304);
    @(negedge clk); addr = 4'd15; ce_n = 0; rd_en = 1; we_n = 1;
    @(negedge clk); smp_valid = 1; smp_i = 16'hA0B0; smp_q = 16'hC0D0;
    @(negedge clk); smp_valid = 0;
    @(negedge clk); ce_n = 1;
    bus_rd(4'd9, 0, d);  chk(d, 8'h05, "R9 single clear per access");
    bus_rd(4'd12, 0, d); chk(d, 8'hB0, "R9 sample loaded during hold");
    bus_rd(4'd15, 0, d); chk(d, 8'hC0, "R9 Q high");

    // R7 legacy strobes, R6 mask
    rd_en = 0;
    bus_wr(4'd9, 8'h00);
    push(16'h5566, 16'h7788);
    chk({15'd0, irq}, 16'd0, "R6 irq masked");
    bus_rd(4'd9, 1, d);  chk(d, 8'h01, "R7 legacy read status");
    bus_rd(4'd15, 1, d); chk(d, 8'h77, "R7 legacy read Q high");
    bus_rd(4'd9, 1, d);  chk(d, 8'h00, "R7 legacy read clears ready");
    @(negedge clk); addr = 4'd3; ce_n = 0; rd_en = 0; we_n = 0;
    @(negedge clk); chk({15'd0, rdata_oe}, 16'd0, "R7 no drive on write");
    ce_n = 1; we_n = 1; rd_en = 1;

    // R8 registered output, unused address; R10 sample bytes read-only
    @(negedge clk); addr = 4'd9; ce_n = 0; rd_en = 1;
    #1 chk({15'd0, rdata_oe}, 16'd0, "R8 oe registered");
    @(negedge clk); chk({15'd0, rdata_oe}, 16'd1, "R8 oe one cycle later");
    ce_n = 1;
    bus_rd(4'd3, 0, d);  chk(d, 8'h00, "R8 unused address");
    bus_wr(4'd12, 8'hFF);
    bus_rd(4'd12, 0, d); chk(d, 8'h66, "R10 sample byte not writable");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule